// File: doc/BRIEF.md
# SPI Master Clock and Delay Sequencer

This block is the timing core of an SPI master. It divides the system clock into a serial clock and drives an active-low chip select. It holds chip select for a programmed setup interval before the first serial clock edge. It then runs one character of a programmed length and inserts a programmed gap after the character. At the end of the gap it either releases chip select or goes straight into the next character. Data shifting is left to a neighbouring block, which uses the launch and sample strobes to know when to drive the next bit and when to capture the incoming one.

An optional prescale bit multiplies the serial half-period by 32. The same bit also scales the setup and gap intervals. Both delay fields have non-zero minimums when they are programmed as zero. The divider, delay fields, prescale bit, polarity, character length and keep-select flag are captured when a start is accepted, so the inputs may change while a character is running.

Top module: `spi_timing_seq`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 0, and launch, sample and done are 0.
- R2: While no transfer is running, sclk equals the cpol input of the previous cycle.
- R3: A start pulse seen while idle with baud_div >= 2 is accepted, and cs_n is 0 from the next cycle.
- R4: A start pulse seen while idle with baud_div of 0 or 1 has no effect: cs_n stays 1 and sclk stays at the idle level.
- R5: The serial half-period H is baud_div system clocks when prescale is 0, and 32 x baud_div when prescale is 1. The value is taken from the field captured at acceptance.
- R6: A nonzero setup_dly gives setup_dly cycles with cs_n low before the first sclk transition, or 32 x setup_dly cycles when prescale is 1.
- R7: A setup_dly of zero gives a setup interval of H cycles.
- R8: A character is char_bits+1 full sclk periods. Each period starts with a half of H cycles at the level opposite cpol, then a half of H cycles at cpol. sample is high in the first cycle of each leading half, and launch is high in the first cycle of each trailing half.
- R9: After each character, sclk rests at cpol with cs_n low for a gap. The gap is 32 x gap_dly cycles, or 1024 x gap_dly cycles when prescale is 1.
- R10: A gap_dly of zero gives a gap of 4 cycles, or 128 cycles when prescale is 1.
- R11: When no continuation follows, cs_n returns to 1 in the cycle after the last gap cycle, and done is high for exactly that cycle.
- R12: A continuation needs all three of the following: keep_cs was 1 at acceptance, a start pulse arrived during the gap, and baud_div >= 2 at the gap's last cycle. The next character then begins in the cycle after the gap, with no setup interval and with cs_n held low. done pulses in that cycle, and the fields are captured again at that point.
- R13: A start pulse during the setup interval or during a character is ignored: it neither shortens the transfer nor causes a continuation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request pulse |
| keep_cs | input | 1 | Hold chip select across characters when a new start is pending |
| prescale | input | 1 | Selects the divide-by-32 prescale |
| cpol | input | 1 | Idle level of sclk |
| baud_div | input | 8 | Serial clock divider, valid 2..255 |
| setup_dly | input | 8 | Setup interval field |
| gap_dly | input | 8 | Inter-character gap field |
| char_bits | input | 4 | Bits per character minus one |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| launch | output | 1 | Strobe at each trailing sclk edge |
| sample | output | 1 | Strobe at each leading sclk edge |
| done | output | 1 | One-cycle end-of-character pulse |

## Verification
The main stimulus is a sweep over divider values 2 to 4, setup fields 0 to 2, gap fields 0 and 1, one to three bits, and both polarities. Each transfer is compared cycle by cycle against an arithmetic waveform. The zero-field cases separate the minimum rules from the scaled ones, and the divider sweep separates H from the setup interval. Prescaled runs with zero and nonzero fields check the 32, 128 and 1024 factors. A further set of runs places a start pulse in the first or last gap cycle, in the setup interval, or mid-character, or removes the divider at the gap's end. These runs separate a legal continuation from the ignored and refused cases.

// File: rtl/spi_seq_pkg.sv
// Shared types of the SPI timing sequencer.
package spi_seq_pkg;
    // Phases of one chip-select frame.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spi_len_calc.sv
// Computes the half-period, setup and gap lengths, in system clocks, from
// the raw fields. Purely combinational. It assumes CNT_W can hold the
// largest gap: gap field shifted by GAP_PS_SHIFT.
module spi_len_calc #(
    parameter int DIV_W        = 8,
    parameter int DLY_W        = 8,
    parameter int CNT_W        = 18,
    parameter int PS_SHIFT     = 5,
    parameter int GAP_SHIFT    = 5,
    parameter int GAP_PS_SHIFT = 10,
    parameter int GAP_MIN      = 4,
    parameter int GAP_MIN_PS   = 128
) (
    input  logic [DIV_W-1:0] div_in,
    input  logic [DLY_W-1:0] setup_in,
    input  logic [DLY_W-1:0] gap_in,
    input  logic             ps_in,
    output logic [CNT_W-1:0] half_len,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] gap_len,
    output logic             div_ok
);
    // Length arithmetic for each interval.
    always_comb begin
        half_len = ps_in ? (CNT_W'(div_in) << PS_SHIFT) : CNT_W'(div_in);
        if (setup_in == '0)
            setup_len = half_len;
        else
            setup_len = ps_in ? (CNT_W'(setup_in) << PS_SHIFT) : CNT_W'(setup_in);
        if (gap_in == '0)
            gap_len = ps_in ? CNT_W'(GAP_MIN_PS) : CNT_W'(GAP_MIN);
        else
            gap_len = ps_in ? (CNT_W'(gap_in) << GAP_PS_SHIFT)
                            : (CNT_W'(gap_in) << GAP_SHIFT);
        div_ok = (div_in >= DIV_W'(2));
    end
endmodule

// File: rtl/spi_down_cnt.sv
// Load-and-count-down interval timer. A loaded value L makes 'last' rise
// L-1 cycles later, so the owning phase lasts exactly L cycles. It assumes
// loads are never zero.
module spi_down_cnt #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count register: load, or step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/spi_half_track.sv
// Counts sclk half-periods within one character. The count is 2*(nbits_m1+1)
// halves; 'odd' marks a trailing half. It assumes clr and inc never coincide.
module spi_half_track #(
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [BITS_W-1:0] nbits_m1,
    output logic              last_half,
    output logic              odd
);
    logic [BITS_W:0] hc;

    // Half-period index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hc <= '0;
        else if (clr)
            hc <= '0;
        else if (inc)
            hc <= hc + 1'b1;
    end

    assign last_half = (hc == {nbits_m1, 1'b1});
    assign odd       = hc[0];
endmodule

// File: rtl/spi_timing_seq.sv
// SPI master timing sequencer: chip select, setup interval, serial clock,
// edge strobes and inter-character gap. Fields are captured at start
// acceptance. It assumes start is a pulse, and that data movement is done
// elsewhere from the strobes.
module spi_timing_seq #(
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              keep_cs,
    input  logic              prescale,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DLY_W-1:0]  setup_dly,
    input  logic [DLY_W-1:0]  gap_dly,
    input  logic [BITS_W-1:0] char_bits,
    output logic              sclk,
    output logic              cs_n,
    output logic              launch,
    output logic              sample,
    output logic              done
);
    import spi_seq_pkg::*;

    localparam int PS_SHIFT     = 5;
    localparam int GAP_SHIFT    = 5;
    localparam int GAP_PS_SHIFT = 10;
    localparam int HALF_W       = DIV_W + PS_SHIFT;
    localparam int GAPW         = DLY_W + GAP_PS_SHIFT;
    localparam int CNT_W        = (HALF_W > GAPW) ? HALF_W : GAPW;

    seq_state_t         st, st_d;
    logic [CNT_W-1:0]   half_len, setup_len, gap_len;
    logic [CNT_W-1:0]   half_l, gap_l, ld_val;
    logic [BITS_W-1:0]  nb_l;
    logic               keep_l, pend, div_ok;
    logic               ld, take, hc_clr, hc_inc, cnt_last, hc_last, hc_odd;
    logic               sclk_q, sclk_d, lau_d, sam_d, done_d;
    logic               lau_q, sam_q, done_q;

    spi_len_calc #(
        .DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .PS_SHIFT(PS_SHIFT),
        .GAP_SHIFT(GAP_SHIFT), .GAP_PS_SHIFT(GAP_PS_SHIFT),
        .GAP_MIN(4), .GAP_MIN_PS(128)
    ) u_calc (
        .div_in(baud_div), .setup_in(setup_dly), .gap_in(gap_dly),
        .ps_in(prescale), .half_len(half_len), .setup_len(setup_len),
        .gap_len(gap_len), .div_ok(div_ok)
    );

    spi_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .last(cnt_last)
    );

    spi_half_track #(.BITS_W(BITS_W)) u_half (
        .clk(clk), .rst_n(rst_n), .clr(hc_clr), .inc(hc_inc),
        .nbits_m1(nb_l), .last_half(hc_last), .odd(hc_odd)
    );

    // Phase sequencing, timer loads and next output values.
    always_comb begin
        st_d   = st;
        ld     = 1'b0;
        ld_val = half_l;
        take   = 1'b0;
        hc_clr = 1'b0;
        hc_inc = 1'b0;
        sclk_d = sclk_q;
        lau_d  = 1'b0;
        sam_d  = 1'b0;
        done_d = 1'b0;
        case (st)
            ST_IDLE: begin
                sclk_d = cpol;
                if (start && div_ok) begin
                    st_d   = ST_SETUP;
                    take   = 1'b1;
                    ld     = 1'b1;
                    ld_val = setup_len;
                end
            end
            ST_SETUP: begin
                if (cnt_last) begin
                    st_d   = ST_SHIFT;
                    ld     = 1'b1;
                    hc_clr = 1'b1;
                    sclk_d = ~sclk_q;
                    sam_d  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cnt_last) begin
                    ld = 1'b1;
                    if (hc_last) begin
                        st_d   = ST_GAP;
                        ld_val = gap_l;
                    end else begin
                        hc_inc = 1'b1;
                        sclk_d = ~sclk_q;
                        lau_d  = ~hc_odd;
                        sam_d  = hc_odd;
                    end
                end
            end
            default: begin
                if (cnt_last) begin
                    done_d = 1'b1;
                    if (keep_l && (pend || start) && div_ok) begin
                        st_d   = ST_SHIFT;
                        take   = 1'b1;
                        ld     = 1'b1;
                        ld_val = half_len;
                        hc_clr = 1'b1;
                        sclk_d = ~cpol;
                        sam_d  = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // State, captured fields, pending-start flag and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            half_l <= '0;
            gap_l  <= '0;
            nb_l   <= '0;
            keep_l <= 1'b0;
            pend   <= 1'b0;
            sclk_q <= 1'b0;
            lau_q  <= 1'b0;
            sam_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st     <= st_d;
            sclk_q <= sclk_d;
            lau_q  <= lau_d;
            sam_q  <= sam_d;
            done_q <= done_d;
            pend   <= (st == ST_GAP && st_d == ST_GAP) ? (pend | start) : 1'b0;
            if (take) begin
                half_l <= half_len;
                gap_l  <= gap_len;
                nb_l   <= char_bits;
                keep_l <= keep_cs;
            end
        end
    end

    assign sclk   = sclk_q;
    assign cs_n   = (st == ST_IDLE);
    assign launch = lau_q;
    assign sample = sam_q;
    assign done   = done_q;
endmodule

// File: rtl/spi_seq_chk.sv
// Port-level properties of the SPI timing sequencer, bound to the top.
module spi_seq_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cpol,
    input logic [DIV_W-1:0] baud_div,
    input logic             sclk,
    input logic             cs_n,
    input logic             launch,
    input logic             sample,
    input logic             done
);
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(rst_n)) |-> (sclk == $past(cpol)));

    assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && start && baud_div >= DIV_W'(2)) |=> !cs_n);

    assert_start_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && start && baud_div < DIV_W'(2)) |=> cs_n);

    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch && sample));

    assert_strobe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch || sample) |-> !cs_n);

    assert_edge_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (sclk != $past(sclk))) |-> (launch || sample));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_release_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);
endmodule

bind spi_timing_seq spi_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .baud_div(baud_div),
    .sclk(sclk), .cs_n(cs_n), .launch(launch), .sample(sample), .done(done)
);

// File: tb/sim_spi_timing_seq.sv
module sim_spi_timing_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, keep_cs = 1'b0, prescale = 1'b0, cpol = 1'b0;
    logic [7:0] baud_div = 8'd0, setup_dly = 8'd0, gap_dly = 8'd0;
    logic [3:0] char_bits = 4'd0;
    logic       sclk, cs_n, launch, sample, done;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    spi_timing_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .keep_cs(keep_cs),
        .prescale(prescale), .cpol(cpol), .baud_div(baud_div),
        .setup_dly(setup_dly), .gap_dly(gap_dly), .char_bits(char_bits),
        .sclk(sclk), .cs_n(cs_n), .launch(launch), .sample(sample), .done(done)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {sclk, launch, sample} inside a character, m counted from 1.
    function automatic logic [2:0] shift_at(int m, int H, logic cp);
        int j = (m - 1) / H;
        int r = (m - 1) % H;
        logic ck = (j % 2 == 0) ? ~cp : cp;
        return {ck, (r == 0) && (j % 2 == 1), (r == 0) && (j % 2 == 0)};
    endfunction

    // Expected {cs_n, sclk, launch, sample, done} k cycles after acceptance.
    function automatic logic [4:0] model(int k, int S, int H, int nb, int G,
                                         logic cp, bit chain);
        int F = 2 * nb * H;
        int T1 = S + F + G;
        int m;
        logic [2:0] sh;
        if (k <= S) return {1'b0, cp, 3'b000};
        if (k <= S + F) begin
            sh = shift_at(k - S, H, cp);
            return {1'b0, sh, 1'b0};
        end
        if (k <= T1) return {1'b0, cp, 3'b000};
        if (!chain) return {1'b1, cp, 2'b00, k == T1 + 1};
        m = k - T1;
        if (m <= F) begin
            sh = shift_at(m, H, cp);
            return {1'b0, sh, m == 1};
        end
        if (m <= F + G) return {1'b0, cp, 3'b000};
        return {1'b1, cp, 2'b00, m == F + G + 1};
    endfunction

    // One transfer. pend_at: cycle at whose negedge a second start is driven
    // (0 = none). kill: also drop the divider to 1 at that cycle.
    task automatic run_xfer(int div, int su, int gp, int nbf, bit ps, bit cp,
                            bit keep, int pend_at, bit kill, bit chain,
                            string tag);
        int H = ps ? 32 * div : div;
        int S = (su == 0) ? H : (ps ? 32 * su : su);
        int G = (gp == 0) ? (ps ? 128 : 4) : (ps ? 1024 * gp : 32 * gp);
        int nb = nbf + 1;
        int F = 2 * nb * H;
        int total = S + F + G + (chain ? F + G : 0) + 3;
        int bad_k[5];
        logic [4:0] bad_a, bad_e;
        string names[5] = '{"done R11 R12", "sample R8", "launch R8",
                            "sclk R5 R7 R8", "cs_n R3 R6 R9 R10 R11 R12"};
        for (int i = 0; i < 5; i++) bad_k[i] = 0;
        bad_a = '0;
        bad_e = '0;
        @(negedge clk);
        baud_div = 8'(div); setup_dly = 8'(su); gap_dly = 8'(gp);
        char_bits = 4'(nbf); prescale = ps; cpol = cp; keep_cs = keep;
        start = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= total; k++) begin
            logic [4:0] a = {cs_n, sclk, launch, sample, done};
            logic [4:0] e = model(k, S, H, nb, G, cp, chain);
            for (int i = 0; i < 5; i++)
                if (a[i] !== e[i] && bad_k[i] == 0) begin
                    bad_k[i] = k; bad_a[i] = a[i]; bad_e[i] = e[i];
                end
            start = (k == pend_at);
            if (kill && k == pend_at) baud_div = 8'd1;
            @(negedge clk);
        end
        start = 1'b0;
        baud_div = 8'(div);
        for (int i = 0; i < 5; i++) begin
            if (bad_k[i] != 0)
                $display("  %s: mismatch at cycle %0d (div=%0d su=%0d gap=%0d bits=%0d ps=%0d)",
                         tag, bad_k[i], div, su, gp, nb, ps);
            chk(bad_k[i] == 0, {tag, " ", names[i]}, int'(bad_a[i]), int'(bad_e[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk(cs_n === 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sclk === 1'b0, "R1 sclk in reset", int'(sclk), 0);
        chk({launch, sample, done} === 3'b000, "R1 strobes in reset",
            int'({launch, sample, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle sclk tracks cpol one cycle later
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk === 1'b1, "R2 idle sclk follows cpol high", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk === 1'b0, "R2 idle sclk follows cpol low", int'(sclk), 0);
        // R4: disabled divider refuses start
        for (int d = 0; d < 2; d++) begin
            baud_div = 8'(d); cpol = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 12; k++) begin
                chk(cs_n === 1'b1 && sclk === 1'b1 && launch === 1'b0 && sample === 1'b0,
                    "R4 start refused with divider 0/1",
                    int'({cs_n, sclk, launch, sample}), 12);
                @(negedge clk);
            end
        end
        // Main sweep: R3 R5 R6 R7 R8 R9 R10 R11
        for (int div = 2; div <= 4; div++)
            for (int su = 0; su <= 2; su++)
                for (int gp = 0; gp <= 1; gp++)
                    for (int nbf = 0; nbf <= 2; nbf++)
                        for (int cp = 0; cp <= 1; cp++)
                            run_xfer(div, su, gp, nbf, 1'b0, cp[0], 1'b0, 0, 1'b0,
                                     1'b0, "sweep");
        // Prescaled runs: R5 R6 R7 R9 R10
        run_xfer(2, 0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "prescale zero fields");
        run_xfer(2, 3, 1, 1, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, "prescale set fields");
        // R12: continuation with start at first and last gap cycle
        // (div 3, setup 2, gap 0 -> S=2, H=3, nb=2, F=12, G=4, gap cycles 15..18)
        run_xfer(3, 2, 0, 1, 1'b0, 1'b0, 1'b1, 15, 1'b0, 1'b1, "R12 start first gap cycle");
        run_xfer(3, 2, 0, 1, 1'b0, 1'b1, 1'b1, 18, 1'b0, 1'b1, "R12 start last gap cycle");
        // R12: keep_cs low means release even with a start in the gap
        run_xfer(3, 2, 0, 1, 1'b0, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R12 keep low releases");
        // R12: divider disabled at gap end refuses the continuation
        run_xfer(3, 2, 0, 1, 1'b0, 1'b0, 1'b1, 18, 1'b1, 1'b0, "R12 divider dropped");
        // R13: start during setup and mid-character is ignored
        run_xfer(3, 2, 0, 1, 1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R13 start in setup");
        run_xfer(3, 2, 0, 1, 1'b0, 1'b1, 1'b1, 7, 1'b0, 1'b0, "R13 start mid character");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule